// File: doc/BRIEF.md
# Core Module System Control Register Block

This block holds the housekeeping registers of a processor core module behind a simple word-addressed bus. A transfer places a byte offset on the address port, and the block uses that offset shifted right by two as the word index. Write strobes take effect on the rising clock edge. Read data is combinational from the current address. The block has fixed identification and status words, and a set of oscillator words that can only be written after a 16-bit key is stored in a lock register. It also has a control word, SDRAM and init words, and two flag registers, each with its own set address and clear address. A 32-bit reference counter advances on a 24 MHz enable strobe, and a read-only window returns a small serial-presence-detect table.

The control word has two side effects. Bit 2 drives a remap output, which moves boot flash out of address zero when it is set. Writing bit 3 produces a one-cycle reset request. The parameter `MEM_MB` gives the attached memory size in megabytes. It sets a size code in the SDRAM reset value and the last entry of the presence-detect table.

Top module: `cmod_sysctl`

## Requirements
- R1: The word index is the byte offset divided by four. Word 0 reads 0x411A3001, word 1 reads 0, and word 4 reads 0x00100000.
- R2: A write to word 5 keeps the low 16 bits of the data. Word 5 reads 0x0001A05F while the stored value is 0xA05F, and reads the stored value otherwise.
- R3: A write to word 2 (oscillator) or word 7 (auxiliary oscillator) updates the register only while the lock holds 0xA05F. Otherwise the register keeps its value.
- R4: A write to word 3 with data bit 3 set drives `resetReq` high for exactly the cycle after the write. Word 3 stores only data bits 0 and 2, and every other bit of word 3 reads 0.
- R5: `remapOut` equals stored control bit 2. A value of 1 means flash is removed from address zero.
- R6: Word 12 reads the flags. A write to word 12 ORs data into the flags, and a write to word 13 clears the flag bits that are set in the data. Words 14 and 15 do the same for the non-volatile flags, which read at word 14. Words 13 and 15 read 0.
- R7: Word 10 reads a 32-bit counter. The counter adds one, modulo 2^32, at each clock edge where `refTick` is high, and holds its value otherwise.
- R8: After reset the registers hold these values:
  - oscillator 0x01000048
  - auxiliary oscillator 0x0007FEFF
  - SDRAM 0x00011122 OR (size code << 2), where the size code is 4, 3, 2 or 1 for MEM_MB of at least 256, 128, 64 or 32, and 0 otherwise (default 128 gives 0x0001112E)
  - init 0x00000112
  - control, lock, flags, non-volatile flags and counter 0
- R9: Byte offsets 0x100 to 0x17F return entry (offset-0x100)/4 of a 32-entry byte table, zero-extended. Entry 0 is 0x80, and entry 31 is MEM_MB/4 capped at 255 (default 32). Offsets 0x180 to 0x1FF read 0.
- R10: Reads of words with no register return 0. Writes to those words, and to the read-only words 0, 1, 4 and 10, change no state.
- R11: Words 8 (SDRAM) and 9 (init) store and read back all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte offset of the access |
| wrEn | input | 1 | Write strobe for the addressed word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the addressed word |
| refTick | input | 1 | 24 MHz reference enable for the counter |
| remapOut | output | 1 | 1 removes boot flash from address zero |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench writes the oscillator words with the lock cleared, with a wrong key, with the key, and after relocking. A design that ignored the key would let locked writes through. A design that checked only part of the key would accept the wrong key. A design that forgot the extra readback bit would return 0xA05F from the lock word.

Control writes carry bit 3 together with the remap bit. A stored or sticky reset bit would then read back as 1, or hold `resetReq` high for more than one cycle.

The flag tests use set and clear patterns that overlap. A design that swapped OR and AND-NOT, or that routed the non-volatile pair to the plain flags, would read back the wrong word. Counter reads follow gapped tick patterns, so a counter that ran freely or counted twice per tick would drift from the model.

// File: rtl/cmod_pkg.sv
package cmod_pkg;

  typedef struct packed {
    logic osc;
    logic ctrl;
    logic lock;
    logic aux;
    logic sdram;
    logic init;
    logic flagSet;
    logic flagClr;
    logic nvSet;
    logic nvClr;
  } wrStrobe_t;

  localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
  localparam logic [31:0] ID_VALUE    = 32'h411A3001;
  localparam logic [31:0] STAT_VALUE  = 32'h00100000;
  localparam logic [31:0] OSC_RST     = 32'h01000048;
  localparam logic [31:0] AUX_RST     = 32'h0007FEFF;
  localparam logic [31:0] SDRAM_BASE  = 32'h00011122;
  localparam logic [31:0] INIT_RST    = 32'h00000112;

  localparam int W_ID     = 0;
  localparam int W_PROC   = 1;
  localparam int W_OSC    = 2;
  localparam int W_CTRL   = 3;
  localparam int W_STAT   = 4;
  localparam int W_LOCK   = 5;
  localparam int W_AUX    = 7;
  localparam int W_SDRAM  = 8;
  localparam int W_INIT   = 9;
  localparam int W_REFCNT = 10;
  localparam int W_FLGSET = 12;
  localparam int W_FLGCLR = 13;
  localparam int W_NVSET  = 14;
  localparam int W_NVCLR  = 15;
  localparam int W_SPD_LO = 64;
  localparam int W_SPD_HI = 95;

endpackage

// File: rtl/cmod_decode.sv
module cmod_decode
  import cmod_pkg::*;
#(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] word,
  output wrStrobe_t         stb
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (int'(word))
        W_OSC:    stb.osc     = 1'b1;
        W_CTRL:   stb.ctrl    = 1'b1;
        W_LOCK:   stb.lock    = 1'b1;
        W_AUX:    stb.aux     = 1'b1;
        W_SDRAM:  stb.sdram   = 1'b1;
        W_INIT:   stb.init    = 1'b1;
        W_FLGSET: stb.flagSet = 1'b1;
        W_FLGCLR: stb.flagClr = 1'b1;
        W_NVSET:  stb.nvSet   = 1'b1;
        W_NVCLR:  stb.nvClr   = 1'b1;
        default:  stb = '0;
      endcase
    end
  end

  // R10: without a write, no register strobe may fire
  a_r10_no_stray_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (stb == '0));
  // R1: at most one register selected per access
  a_r1_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/cmod_datapath.sv
module cmod_datapath
  import cmod_pkg::*;
#(
  parameter int WORD_W = 7,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic [WORD_W-1:0] rdWord,
  input  logic [31:0]       wrData,
  input  logic              refTick,
  output logic [31:0]       rdData,
  output logic              remapOut,
  output logic              resetReq
);

  localparam logic [2:0] SIZE_CODE = (MEM_MB >= 256) ? 3'd4 :
                                     (MEM_MB >= 128) ? 3'd3 :
                                     (MEM_MB >= 64)  ? 3'd2 :
                                     (MEM_MB >= 32)  ? 3'd1 : 3'd0;
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | (32'(SIZE_CODE) << 2);
  localparam int          SPD_LAST_I = (MEM_MB / 4 > 255) ? 255 : MEM_MB / 4;
  localparam logic [7:0]  SPD_LAST  = 8'(SPD_LAST_I);

  logic [31:0] oscQ, auxQ, sdramQ, initQ, flagsQ, nvQ, refCnt;
  logic [15:0] lockQ;
  logic        ledQ, remapQ;
  logic        unlocked;

  assign unlocked = (lockQ == UNLOCK_KEY);

  function automatic logic [7:0] spdByte(input logic [4:0] idx);
    case (idx)
      5'd0:  spdByte = 8'h80;  5'd1:  spdByte = 8'h08;
      5'd2:  spdByte = 8'h04;  5'd3:  spdByte = 8'h0B;
      5'd4:  spdByte = 8'h09;  5'd5:  spdByte = 8'h01;
      5'd6:  spdByte = 8'h40;  5'd8:  spdByte = 8'h02;
      5'd9:  spdByte = 8'hA0;  5'd10: spdByte = 8'hA0;
      5'd13: spdByte = 8'h08;  5'd15: spdByte = 8'h01;
      5'd16: spdByte = 8'h0E;  5'd17: spdByte = 8'h04;
      5'd18: spdByte = 8'h1C;  5'd19: spdByte = 8'h01;
      5'd20: spdByte = 8'h02;  5'd21: spdByte = 8'h20;
      5'd22: spdByte = 8'hC0;  5'd27: spdByte = 8'h30;
      5'd28: spdByte = 8'h28;  5'd29: spdByte = 8'h30;
      5'd30: spdByte = 8'h28;  5'd31: spdByte = SPD_LAST;
      default: spdByte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscQ     <= OSC_RST;
      auxQ     <= AUX_RST;
      sdramQ   <= SDRAM_RST;
      initQ    <= INIT_RST;
      lockQ    <= '0;
      ledQ     <= 1'b0;
      remapQ   <= 1'b0;
      flagsQ   <= '0;
      nvQ      <= '0;
      refCnt   <= '0;
      resetReq <= 1'b0;
    end else begin
      if (stb.osc && unlocked) oscQ <= wrData;
      if (stb.aux && unlocked) auxQ <= wrData;
      if (stb.sdram) sdramQ <= wrData;
      if (stb.init)  initQ  <= wrData;
      if (stb.lock)  lockQ  <= wrData[15:0];
      if (stb.ctrl) begin
        ledQ   <= wrData[0];
        remapQ <= wrData[2];
      end
      resetReq <= stb.ctrl & wrData[3];
      if (stb.flagSet) flagsQ <= flagsQ | wrData;
      if (stb.flagClr) flagsQ <= flagsQ & ~wrData;
      if (stb.nvSet)   nvQ    <= nvQ | wrData;
      if (stb.nvClr)   nvQ    <= nvQ & ~wrData;
      if (refTick)     refCnt <= refCnt + 32'd1;
    end
  end

  assign remapOut = remapQ;

  always_comb begin
    rdData = '0;
    case (int'(rdWord))
      W_ID:     rdData = ID_VALUE;
      W_OSC:    rdData = oscQ;
      W_CTRL:   rdData = {29'd0, remapQ, 1'b0, ledQ};
      W_STAT:   rdData = STAT_VALUE;
      W_LOCK:   rdData = {15'd0, unlocked, lockQ};
      W_AUX:    rdData = auxQ;
      W_SDRAM:  rdData = sdramQ;
      W_INIT:   rdData = initQ;
      W_REFCNT: rdData = refCnt;
      W_FLGSET: rdData = flagsQ;
      W_NVSET:  rdData = nvQ;
      default: begin
        if (int'(rdWord) >= W_SPD_LO && int'(rdWord) <= W_SPD_HI)
          rdData = {24'd0, spdByte(rdWord[4:0])};
      end
    endcase
  end

  // R3: a locked oscillator word keeps its value across a write
  a_r3_osc_locked: assert property (@(posedge clk) disable iff (!rstN)
    (stb.osc && !unlocked) |=> $stable(oscQ));
  a_r3_aux_locked: assert property (@(posedge clk) disable iff (!rstN)
    (stb.aux && !unlocked) |=> $stable(auxQ));
  // R4: reset bit in a control write yields a request next cycle
  a_r4_reset_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ctrl && wrData[3]) |=> resetReq);
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctrl |=> !resetReq);
  // R5: remap output follows the written bit
  a_r5_remap_follow: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctrl |=> (remapOut == $past(wrData[2])));
  // R6: a set write leaves every written bit high
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    stb.flagSet |=> ((flagsQ & $past(wrData)) == $past(wrData)));
  a_r6_nv_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.nvClr |=> ((nvQ & $past(wrData)) == 32'd0));
  // R7: counter advances by one on each tick
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> (refCnt == $past(refCnt) + 32'd1));

endmodule

// File: rtl/cmod_sysctl.sv
module cmod_sysctl
  import cmod_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              refTick,
  output logic              remapOut,
  output logic              resetReq
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unusedAddrLow;
  wrStrobe_t         stb;

  assign word          = addr[ADDR_W-1:2];
  assign unusedAddrLow = addr[1:0];

  cmod_decode #(.WORD_W(WORD_W)) uDecode (
    .clk  (clk),
    .rstN (rstN),
    .wrEn (wrEn),
    .word (word),
    .stb  (stb)
  );

  cmod_datapath #(.WORD_W(WORD_W), .MEM_MB(MEM_MB)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdWord   (word),
    .wrData   (wrData),
    .refTick  (refTick),
    .rdData   (rdData),
    .remapOut (remapOut),
    .resetReq (resetReq)
  );

endmodule

// File: tb/sim_cmod_sysctl.sv
`timescale 1ns/1ps
module sim_cmod_sysctl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        refTick = 1'b0;
  logic [31:0] rdData;
  logic        remapOut, resetReq;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmod_sysctl u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .refTick(refTick), .remapOut(remapOut), .resetReq(resetReq)
  );

  // behavioural reference model
  logic [31:0] mOsc, mAux, mSdram, mInit, mFlags, mNv, mCnt;
  logic [15:0] mLock;
  logic        mLed, mRemap, mRst;

  task automatic modelReset();
    mOsc = 32'h01000048; mAux = 32'h0007FEFF;
    mSdram = 32'h0001112E; mInit = 32'h00000112;
    mLock = 0; mLed = 0; mRemap = 0; mFlags = 0; mNv = 0; mCnt = 0; mRst = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      mRst = 1'b0;
      if (wrEn) begin
        case (int'(addr >> 2))
          2:  if (mLock == 16'hA05F) mOsc = wrData;
          3:  begin mLed = wrData[0]; mRemap = wrData[2]; mRst = wrData[3]; end
          5:  mLock = wrData[15:0];
          7:  if (mLock == 16'hA05F) mAux = wrData;
          8:  mSdram = wrData;
          9:  mInit = wrData;
          12: mFlags = mFlags | wrData;
          13: mFlags = mFlags & ~wrData;
          14: mNv = mNv | wrData;
          15: mNv = mNv & ~wrData;
          default: ;
        endcase
      end
      if (refTick) mCnt = mCnt + 1;
    end
  end

  function automatic logic [31:0] expRead(input int a);
    int w = a >> 2;
    if (a == 'h100) return 32'h80;          // R9 entry 0
    if (a == 'h17C) return 32'd32;          // R9 entry 31 for 128 MB
    if (a >= 'h180) return 0;               // R9 upper half zero
    case (w)
      0: return 32'h411A3001;               // R1
      1: return 0;
      2: return mOsc;
      3: return {29'd0, mRemap, 1'b0, mLed};
      4: return 32'h00100000;
      5: return (mLock == 16'hA05F) ? 32'h1A05F : {16'd0, mLock};
      7: return mAux;
      8: return mSdram;
      9: return mInit;
      10: return mCnt;
      12: return mFlags;
      14: return mNv;
      default: return 0;                    // R10
    endcase
  endfunction

  function automatic string tagFor(input int a);
    int w = a >> 2;
    if (a >= 'h100) return "R9";
    case (w)
      0, 1, 4: return "R1";
      5: return "R2";
      2, 7: return "R3";
      3: return "R4";
      8, 9: return "R11";
      10: return "R7";
      12, 13, 14, 15: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at t=%0t addr=0x%0h: actual 0x%08h expected 0x%08h",
               tag, $time, addr, act, exp);
    end
  endtask

  // one bus cycle; checks outputs before the next edge
  task automatic cyc(input bit we, input int a, input logic [31:0] d, input bit tick = 0);
    @(negedge clk);
    wrEn = we; addr = 9'(a); wrData = d; refTick = tick;
    #1;
    compare(tagFor(a), rdData, expRead(a));
    compare("R5", {31'd0, remapOut}, {31'd0, mRemap});
    compare("R4", {31'd0, resetReq}, {31'd0, mRst});
  endtask

  task automatic rd(input int a);
    cyc(0, a, 32'h0);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8, R1, R9: reset readback across the map
    for (int w = 0; w < 16; w++) rd(w * 4);
    rd('h100); rd('h17C); rd('h180); rd('h1FC); rd('h80); rd('h8C);
    // R3: locked writes ignored
    cyc(1, 'h08, 32'hDEADBEEF); rd('h08);
    cyc(1, 'h1C, 32'hCAFEF00D); rd('h1C);
    // R2: wrong key, then key with high bits set
    cyc(1, 'h14, 32'hFFFF1234); rd('h14);
    cyc(1, 'h08, 32'h11111111); rd('h08);
    cyc(1, 'h14, 32'h5555A05F); rd('h14);
    // R3: unlocked writes land
    cyc(1, 'h08, 32'hDEADBEEF); rd('h08);
    cyc(1, 'h1C, 32'h12345678); rd('h1C);
    cyc(1, 'h14, 32'h0000A05E); rd('h14);
    cyc(1, 'h08, 32'h0BADBEEF); rd('h08);
    // R4, R5: reset pulse and remap
    cyc(1, 'h0C, 32'hFFFFFFFF); rd('h0C); rd('h0C);
    cyc(1, 'h0C, 32'h00000008); rd('h0C);
    cyc(1, 'h0C, 32'h00000004); cyc(1, 'h0C, 32'h0000000C); rd('h0C);
    cyc(1, 'h0C, 32'h00000001); rd('h0C);
    // R6: flag pairs with overlapping patterns
    cyc(1, 'h30, 32'h0000F0F0); rd('h30);
    cyc(1, 'h30, 32'h0F000001); rd('h30);
    cyc(1, 'h34, 32'h000000F1); rd('h30); rd('h34);
    cyc(1, 'h38, 32'hAAAA0000); rd('h38); rd('h30);
    cyc(1, 'h3C, 32'h2000FFFF); rd('h38); rd('h3C);
    // R11: full-width SDRAM and init
    cyc(1, 'h20, 32'hFFFFFFFF); rd('h20);
    cyc(1, 'h24, 32'hA5A5_5A5A); rd('h24);
    cyc(1, 'h20, 32'h00000000); rd('h20);
    // R10: writes to holes and read-only words change nothing
    cyc(1, 'h00, 32'hFFFFFFFF); cyc(1, 'h04, 32'hFFFFFFFF);
    cyc(1, 'h10, 32'hFFFFFFFF); cyc(1, 'h18, 32'hFFFFFFFF);
    cyc(1, 'h28, 32'hFFFFFFFF); cyc(1, 'h2C, 32'hFFFFFFFF);
    cyc(1, 'h40, 32'hFFFFFFFF); cyc(1, 'h100, 32'hFFFFFFFF);
    for (int w = 0; w < 16; w++) rd(w * 4);
    rd('h100); rd('h17C); rd('h40); rd('h84);
    // R7: counter under gapped tick patterns
    for (int i = 0; i < 40; i++) cyc(0, 'h28, 0, (i % 3) != 1);
    for (int i = 0; i < 10; i++) cyc(0, 'h28, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 'h28, 0, 1);
    cyc(1, 'h28, 32'h0, 1); rd('h28);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule